// File: doc/BRIEF.md
# Physical Memory Protection Register Bank with Write Locking

This block keeps the programmable state of a physical-memory-protection unit: sixteen entries, each with an 8-bit configuration byte and a 32-bit address register, plus one security register with three flags. Software reaches all of it through a single CSR-style port: write enable, read enable, a 7-bit register selector and a 32-bit data word. Reads return data in the same cycle. Writes land on the next clock edge.

Every write passes through the locking rules before it is stored. A locked entry refuses changes to its configuration byte and its address register. An entry whose neighbour above is locked in top-of-range mode also refuses address writes. The bypass flag overrides configuration locks. The lockdown flag limits which configuration values are accepted. Both lockdown flags are sticky once set.

Alongside the raw registers, the block presents each entry's decoded byte-address range as a start and an end value. It also presents a count of enabled entries. These outputs follow a write in the same cycle as the registers do, so a downstream access checker never sees the registers and the decoded ranges disagree. The block does not check any access against the entries.

Top module: `pmp_csr_bank`

## Requirements
- R1: After reset, every configuration byte, address register, decoded start and end, the enabled-entry count and all three security flags are zero.
- R2: Configuration byte fields are: bit 0 read, bit 1 write, bit 2 execute, bits 4:3 mode (0 off, 1 top-of-range, 2 four-byte, 3 power-of-two), and bit 7 lock. Selector 0x00+n addresses the configuration word n, which holds entries 4n to 4n+3, with entry 4n in bits 7:0 and each following entry eight bits higher. The word reads back in the same packing.
- R3: A byte in a configuration write is dropped when its entry has the lock bit set and the bypass flag is clear. The other bytes of the same write are judged on their own.
- R4: Selector 0x40+k writes address register k. The write is dropped when entry k is locked. It is also dropped when entry k+1 exists, is locked, and is in top-of-range mode.
- R5: A write has no effect, and a read returns zero, for configuration word indices 4 to 31, address indices 16 to 63, and selectors 0x21 to 0x3F. The read data is zero whenever read enable is low.
- R6: Selector 0x20 is the security register, with bit 0 lockdown, bit 1 whitelist and bit 2 bypass. Once the lockdown or whitelist flag is set, it stays set whatever is written later.
- R7: The bypass flag cannot go from 0 to 1 while any entry is locked. Writing 0 always clears it.
- R8: While lockdown is set and bypass is clear, a new configuration byte with its lock bit set is accepted only if its execute bit is clear. A new byte without its lock bit is accepted only if bits 2:0 are not 3'b110.
- R9: The decoded range of entry k, in byte addresses of 34 bits, depends on the mode. Off gives start 0 and end 0. Top-of-range gives start = address k-1 times 4 (0 for entry 0) and end = address k times 4 minus 1, modulo 2^34. Four-byte gives start = address times 4 and end = start+3. Power-of-two with t trailing one bits gives an aligned region of 2^(t+3) bytes containing address times 4. With all 32 bits set, it gives 0 to 2^34-1.
- R10: The enabled-entry count equals the number of entries whose mode is not off.
- R11: The decoded ranges and the count reflect a write in the cycle after it, together with the registers. A read in the same cycle as a write to the same register returns the value from before the write.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset |
| csr_we | input | 1 | Write strobe |
| csr_re | input | 1 | Read strobe |
| csr_sel | input | 7 | Register selector |
| csr_wdata | input | 32 | Write data |
| csr_rdata | output | 32 | Read data, combinational |
| ent_cfg | output | 16x8 | Configuration byte per entry |
| ent_addr | output | 16x32 | Address register per entry |
| ent_start | output | 16x34 | Decoded first byte address per entry |
| ent_end | output | 16x34 | Decoded last byte address per entry |
| active_cnt | output | 5 | Number of entries not in off mode |
| sec_mml | output | 1 | Lockdown flag |
| sec_mmwp | output | 1 | Whitelist flag |
| sec_rlb | output | 1 | Lock bypass flag |

## Verification
A read and a write can fall in the same cycle on the one port. The bench drives both strobes at one selector and expects the read data to show the value from before the write. In the next cycle it expects the new value, along with the decoded range that follows from it. The lock judgement and the store can also meet inside one configuration write, where one byte sets a lock while its neighbours change. Each byte must be judged against the lock state held before that write. The behavioural model and the design are compared on every output in every clock, so each of these outcomes is judged per cycle.

// File: rtl/pmp_bank_pkg.sv
package pmp_bank_pkg;
    typedef enum logic [1:0] {
        AM_OFF   = 2'd0,
        AM_TOR   = 2'd1,
        AM_NA4   = 2'd2,
        AM_NAPOT = 2'd3
    } amode_e;

    localparam int CB_R   = 0;
    localparam int CB_W   = 1;
    localparam int CB_X   = 2;
    localparam int CB_AL  = 3;
    localparam int CB_AH  = 4;
    localparam int CB_L   = 7;

    localparam int SB_MML  = 0;
    localparam int SB_MMWP = 1;
    localparam int SB_RLB  = 2;

    localparam int SEL_W = 7;
    localparam logic [SEL_W-1:0] SEC_SEL = 7'h20;
endpackage

// File: rtl/pmp_cfg_gate.sv
module pmp_cfg_gate (
    input  logic       cur_locked,
    input  logic       new_locked,
    input  logic [2:0] new_rwx,
    input  logic       rlb,
    input  logic       mml,
    output logic       accept
);
    always_comb begin
        if (rlb) begin
            accept = 1'b1;
        end else if (cur_locked) begin
            accept = 1'b0;
        end else if (!mml) begin
            accept = 1'b1;
        end else if (new_locked) begin
            accept = !new_rwx[2];
        end else begin
            accept = (new_rwx != 3'b110);
        end
    end
endmodule

// File: rtl/pmp_range_decode.sv
module pmp_range_decode
    import pmp_bank_pkg::*;
#(
    parameter int XLEN = 32
) (
    input  amode_e            mode,
    input  logic [XLEN-1:0]   addr,
    input  logic [XLEN-1:0]   prev_addr,
    output logic [XLEN+1:0]   start_a,
    output logic [XLEN+1:0]   end_a
);
    localparam int AW = XLEN + 2;
    localparam logic [XLEN-1:0] ONE_X  = 1;
    localparam logic [AW-1:0]   ONE_AW = 1;

    logic [XLEN-1:0] napot_mask;
    logic [AW-1:0]   byte_addr;

    assign napot_mask = addr ^ (addr + ONE_X);
    assign byte_addr  = {addr, 2'b00};

    always_comb begin
        unique case (mode)
            AM_OFF: begin
                start_a = '0;
                end_a   = '0;
            end
            AM_TOR: begin
                start_a = {prev_addr, 2'b00};
                end_a   = byte_addr - ONE_AW;
            end
            AM_NA4: begin
                start_a = byte_addr;
                end_a   = {addr, 2'b11};
            end
            AM_NAPOT: begin
                start_a = {addr & ~napot_mask, 2'b00};
                end_a   = {addr | napot_mask, 2'b11};
            end
            default: begin
                start_a = '0;
                end_a   = '0;
            end
        endcase
    end
endmodule

// File: rtl/pmp_csr_bank.sv
module pmp_csr_bank
    import pmp_bank_pkg::*;
#(
    parameter int NUM_ENT = 16,
    parameter int XLEN    = 32
) (
    input  logic                                 clk,
    input  logic                                 rst_n,
    input  logic                                 csr_we,
    input  logic                                 csr_re,
    input  logic [6:0]                           csr_sel,
    input  logic [XLEN-1:0]                      csr_wdata,
    output logic [XLEN-1:0]                      csr_rdata,
    output logic [NUM_ENT-1:0][7:0]              ent_cfg,
    output logic [NUM_ENT-1:0][XLEN-1:0]         ent_addr,
    output logic [NUM_ENT-1:0][XLEN+1:0]         ent_start,
    output logic [NUM_ENT-1:0][XLEN+1:0]         ent_end,
    output logic [$clog2(NUM_ENT+1)-1:0]         active_cnt,
    output logic                                 sec_mml,
    output logic                                 sec_mmwp,
    output logic                                 sec_rlb
);
    localparam int CPC   = XLEN / 8;
    localparam int AW    = XLEN + 2;
    localparam int CNT_W = $clog2(NUM_ENT + 1);
    localparam logic [CNT_W-1:0] CNT_ONE = 1;

    // selector decode
    logic sel_is_cfg, sel_is_addr, sel_is_sec;
    assign sel_is_addr = csr_sel[6];
    assign sel_is_cfg  = (csr_sel[6:5] == 2'b00);
    assign sel_is_sec  = (csr_sel == SEC_SEL);

    // state
    logic [NUM_ENT-1:0][7:0]      cfg_q,   cfg_d;
    logic [NUM_ENT-1:0][XLEN-1:0] addr_q,  addr_d;
    logic [NUM_ENT-1:0][AW-1:0]   start_q, start_d;
    logic [NUM_ENT-1:0][AW-1:0]   end_q,   end_d;
    logic [CNT_W-1:0]             cnt_q,   cnt_d;
    logic sec_mml_q, sec_mmwp_q, sec_rlb_q;
    logic sec_mml_d, sec_mmwp_d, sec_rlb_d;
    logic any_locked;

    // per-entry write gating and range decode
    for (genvar i = 0; i < NUM_ENT; i++) begin : g_ent
        localparam int CSR_N  = i / CPC;
        localparam int BYTE_N = i % CPC;

        logic            cfg_hit, cfg_ok, addr_hit, tor_lock;
        logic [7:0]      cfg_new;
        logic [XLEN-1:0] prev_a;

        assign cfg_hit  = csr_we && sel_is_cfg && (int'(csr_sel[4:0]) == CSR_N);
        assign cfg_new  = csr_wdata[BYTE_N*8 +: 8];

        pmp_cfg_gate u_gate (
            .cur_locked (cfg_q[i][CB_L]),
            .new_locked (cfg_new[CB_L]),
            .new_rwx    (cfg_new[CB_X:CB_R]),
            .rlb        (sec_rlb_q),
            .mml        (sec_mml_q),
            .accept     (cfg_ok)
        );

        assign cfg_d[i] = (cfg_hit && cfg_ok) ? cfg_new : cfg_q[i];

        if (i + 1 < NUM_ENT) begin : g_nxt
            assign tor_lock = cfg_q[i+1][CB_L] &&
                              (cfg_q[i+1][CB_AH:CB_AL] == AM_TOR);
        end else begin : g_top
            assign tor_lock = 1'b0;
        end

        assign addr_hit  = csr_we && sel_is_addr && (int'(csr_sel[5:0]) == i);
        assign addr_d[i] = (addr_hit && !cfg_q[i][CB_L] && !tor_lock)
                           ? csr_wdata : addr_q[i];

        if (i == 0) begin : g_first
            assign prev_a = '0;
        end else begin : g_rest
            assign prev_a = addr_d[i-1];
        end

        pmp_range_decode #(.XLEN(XLEN)) u_dec (
            .mode      (amode_e'(cfg_d[i][CB_AH:CB_AL])),
            .addr      (addr_d[i]),
            .prev_addr (prev_a),
            .start_a   (start_d[i]),
            .end_a     (end_d[i])
        );

        // R3
        cfg_lock_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
            (cfg_q[i][CB_L] && !sec_rlb_q) |=> $stable(cfg_q[i]));

        // R4
        addr_lock_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
            cfg_q[i][CB_L] |=> $stable(addr_q[i]));

        // R8
        mml_value_chk: assert property (@(posedge clk) disable iff (!rst_n)
            (sec_mml_q && !sec_rlb_q) |=>
                ($stable(cfg_q[i]) || !(cfg_q[i][CB_L] && cfg_q[i][CB_X])));
    end

    // enabled-entry count from the next-state bytes
    always_comb begin
        cnt_d = '0;
        for (int e = 0; e < NUM_ENT; e++) begin
            if (cfg_d[e][CB_AH:CB_AL] != AM_OFF) cnt_d = cnt_d + CNT_ONE;
        end
    end

    // security register: sticky lockdown flags, guarded bypass
    always_comb begin
        any_locked = 1'b0;
        for (int e = 0; e < NUM_ENT; e++) begin
            any_locked = any_locked | cfg_q[e][CB_L];
        end
    end

    always_comb begin
        sec_mml_d  = sec_mml_q;
        sec_mmwp_d = sec_mmwp_q;
        sec_rlb_d  = sec_rlb_q;
        if (csr_we && sel_is_sec) begin
            sec_mml_d  = sec_mml_q  | csr_wdata[SB_MML];
            sec_mmwp_d = sec_mmwp_q | csr_wdata[SB_MMWP];
            sec_rlb_d  = csr_wdata[SB_RLB] && (sec_rlb_q || !any_locked);
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cfg_q      <= '0;
            addr_q     <= '0;
            start_q    <= '0;
            end_q      <= '0;
            cnt_q      <= '0;
            sec_mml_q  <= 1'b0;
            sec_mmwp_q <= 1'b0;
            sec_rlb_q  <= 1'b0;
        end else begin
            cfg_q      <= cfg_d;
            addr_q     <= addr_d;
            start_q    <= start_d;
            end_q      <= end_d;
            cnt_q      <= cnt_d;
            sec_mml_q  <= sec_mml_d;
            sec_mmwp_q <= sec_mmwp_d;
            sec_rlb_q  <= sec_rlb_d;
        end
    end

    // read mux, combinational from current state
    always_comb begin
        csr_rdata = '0;
        if (csr_re) begin
            if (sel_is_cfg) begin
                for (int e = 0; e < NUM_ENT; e++) begin
                    if (int'(csr_sel[4:0]) == e / CPC)
                        csr_rdata[(e % CPC)*8 +: 8] = cfg_q[e];
                end
            end else if (sel_is_addr) begin
                for (int e = 0; e < NUM_ENT; e++) begin
                    if (int'(csr_sel[5:0]) == e) csr_rdata = addr_q[e];
                end
            end else if (sel_is_sec) begin
                csr_rdata[SB_MML]  = sec_mml_q;
                csr_rdata[SB_MMWP] = sec_mmwp_q;
                csr_rdata[SB_RLB]  = sec_rlb_q;
            end
        end
    end

    assign ent_cfg    = cfg_q;
    assign ent_addr   = addr_q;
    assign ent_start  = start_q;
    assign ent_end    = end_q;
    assign active_cnt = cnt_q;
    assign sec_mml    = sec_mml_q;
    assign sec_mmwp   = sec_mmwp_q;
    assign sec_rlb    = sec_rlb_q;

    // R6
    mml_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
        sec_mml_q |=> sec_mml_q);

    // R6
    mmwp_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
        sec_mmwp_q |=> sec_mmwp_q);

    // R7
    rlb_guard_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!sec_rlb_q && any_locked) |=> !sec_rlb_q);

    // R5
    oob_addr_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (csr_we && sel_is_addr && (int'(csr_sel[5:0]) >= NUM_ENT)) |=> $stable(addr_q));
endmodule

// File: tb/pmp_csr_bank_bench.sv
module pmp_csr_bank_bench;
    localparam int N  = 16;
    localparam int XL = 32;
    localparam int AW = 34;
    localparam logic [AW-1:0] MASK34 = '1;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic csr_we = 1'b0, csr_re = 1'b0;
    logic [6:0] csr_sel = '0;
    logic [XL-1:0] csr_wdata = '0;
    logic [XL-1:0] csr_rdata;
    logic [N-1:0][7:0]    ent_cfg;
    logic [N-1:0][XL-1:0] ent_addr;
    logic [N-1:0][AW-1:0] ent_start, ent_end;
    logic [4:0] active_cnt;
    logic sec_mml, sec_mmwp, sec_rlb;

    always #5 clk = ~clk;

    pmp_csr_bank u_pmp_csr_bank (
        .clk(clk), .rst_n(rst_n), .csr_we(csr_we), .csr_re(csr_re),
        .csr_sel(csr_sel), .csr_wdata(csr_wdata), .csr_rdata(csr_rdata),
        .ent_cfg(ent_cfg), .ent_addr(ent_addr), .ent_start(ent_start),
        .ent_end(ent_end), .active_cnt(active_cnt), .sec_mml(sec_mml),
        .sec_mmwp(sec_mmwp), .sec_rlb(sec_rlb)
    );

    // behavioural model
    logic [7:0]  m_cfg  [N];
    logic [31:0] m_addr [N];
    bit m_mml, m_mmwp, m_rlb;
    int vectors = 0, miscompares = 0;
    string req = "R1";

    function automatic logic [AW-1:0] exp_start(int i);
        logic [31:0] a = m_addr[i];
        logic [AW-1:0] r;
        case (m_cfg[i][4:3])
            2'd1: r = (i == 0) ? '0 : {m_addr[i-1], 2'b00};
            2'd2: r = {a, 2'b00};
            2'd3: begin
                int t = 0;
                longint unsigned sz;
                while (t < 32 && a[t]) t++;
                sz = 64'd1 << (t + 3);
                r = AW'((longint'({a, 2'b00}) & ~(sz - 1)));
            end
            default: r = '0;
        endcase
        return r;
    endfunction

    function automatic logic [AW-1:0] exp_end(int i);
        logic [31:0] a = m_addr[i];
        logic [AW-1:0] r;
        case (m_cfg[i][4:3])
            2'd1: r = ({a, 2'b00} - 34'd1) & MASK34;
            2'd2: r = {a, 2'b00} + 34'd3;
            2'd3: begin
                int t = 0;
                longint unsigned sz;
                while (t < 32 && a[t]) t++;
                sz = 64'd1 << (t + 3);
                r = AW'(((longint'({a, 2'b00}) & ~(sz - 1)) + sz - 1));
            end
            default: r = '0;
        endcase
        return r;
    endfunction

    function automatic logic [31:0] model_read(logic [6:0] sel);
        logic [31:0] r = '0;
        if (sel[6]) begin
            if (int'(sel[5:0]) < N) r = m_addr[sel[5:0]];
        end else if (sel[6:5] == 2'b00) begin
            for (int b = 0; b < 4; b++) begin
                int idx = int'(sel[4:0]) * 4 + b;
                if (idx < N) r[b*8 +: 8] = m_cfg[idx];
            end
        end else if (sel == 7'h20) begin
            r = {29'd0, m_rlb, m_mmwp, m_mml};
        end
        return r;
    endfunction

    task automatic model_write(logic [6:0] sel, logic [31:0] wd);
        if (sel[6]) begin
            int idx = int'(sel[5:0]);
            if (idx < N) begin
                bit lk = m_cfg[idx][7];
                if (idx + 1 < N && m_cfg[idx+1][7] && m_cfg[idx+1][4:3] == 2'd1) lk = 1;
                if (!lk) m_addr[idx] = wd;
            end
        end else if (sel[6:5] == 2'b00) begin
            for (int b = 0; b < 4; b++) begin
                int idx = int'(sel[4:0]) * 4 + b;
                if (idx < N) begin
                    logic [7:0] v = wd[b*8 +: 8];
                    bit ok;
                    if (m_rlb) ok = 1;
                    else if (m_cfg[idx][7]) ok = 0;
                    else if (!m_mml) ok = 1;
                    else if (v[7]) ok = !v[2];
                    else ok = (v[2:0] != 3'b110);
                    if (ok) m_cfg[idx] = v;
                end
            end
        end else if (sel == 7'h20) begin
            bit anylk = 0;
            for (int e = 0; e < N; e++) anylk |= m_cfg[e][7];
            m_mml  = m_mml  | wd[0];
            m_mmwp = m_mmwp | wd[1];
            m_rlb  = wd[2] && (m_rlb || !anylk);
        end
    endtask

    task automatic chk(string what, logic [63:0] act, logic [63:0] exp);
        if (act !== exp) begin
            miscompares++;
            $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
        end
    endtask

    task automatic compare_state();
        int cnt = 0;
        vectors++;
        for (int i = 0; i < N; i++) begin
            chk($sformatf("cfg[%0d]", i),   64'(ent_cfg[i]),   64'(m_cfg[i]));
            chk($sformatf("addr[%0d]", i),  64'(ent_addr[i]),  64'(m_addr[i]));
            chk($sformatf("start[%0d]", i), 64'(ent_start[i]), 64'(exp_start(i)));
            chk($sformatf("end[%0d]", i),   64'(ent_end[i]),   64'(exp_end(i)));
            if (m_cfg[i][4:3] != 2'd0) cnt++;
        end
        chk("count (R10)", 64'(active_cnt), 64'(cnt));
        chk("mml", 64'(sec_mml), 64'(m_mml));
        chk("mmwp", 64'(sec_mmwp), 64'(m_mmwp));
        chk("rlb", 64'(sec_rlb), 64'(m_rlb));
    endtask

    task automatic op(bit we, bit re, logic [6:0] sel, logic [31:0] wd, string tag);
        @(negedge clk);
        req = tag;
        csr_we = we; csr_re = re; csr_sel = sel; csr_wdata = wd;
        #1;
        compare_state();
        chk("rdata", 64'(csr_rdata), re ? 64'(model_read(sel)) : 64'd0);
        if (we) model_write(sel, wd);
    endtask

    initial begin
        for (int i = 0; i < N; i++) begin m_cfg[i] = '0; m_addr[i] = '0; end
        m_mml = 0; m_mmwp = 0; m_rlb = 0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        // R1 reset state
        op(0, 1, 7'h00, 0, "R1");
        op(0, 1, 7'h20, 0, "R1");
        // R2 packing, R9 decode per mode
        op(1, 0, 7'h00, 32'h1B_10_0F_0B, "R2");
        op(1, 0, 7'h40, 32'h0000_0100, "R9");
        op(1, 0, 7'h42, 32'h2000_0000, "R9");
        op(1, 0, 7'h43, 32'h0000_00FF, "R9");
        op(0, 1, 7'h00, 0, "R2");
        op(0, 1, 7'h43, 0, "R2");
        // R11 read during write
        op(1, 1, 7'h41, 32'h0000_0055, "R11");
        op(0, 1, 7'h41, 0, "R11");
        op(1, 1, 7'h40, 32'h0000_0000, "R11");
        // R5 out of range
        op(1, 1, 7'h50, 32'hDEAD_BEEF, "R5");
        op(1, 1, 7'h04, 32'hFFFF_FFFF, "R5");
        op(1, 1, 7'h21, 32'hFFFF_FFFF, "R5");
        op(0, 0, 7'h40, 0, "R5");
        op(0, 1, 7'h7F, 0, "R5");
        // R10 count
        op(1, 0, 7'h00, 32'h00_00_00_00, "R10");
        op(1, 0, 7'h00, 32'h18_08_10_08, "R10");
        // R6/R7 bypass set while nothing locked
        op(1, 1, 7'h20, 32'h4, "R7");
        op(0, 1, 7'h20, 0, "R6");
        // entries 4/5, then lock 5
        op(1, 0, 7'h44, 32'hFFFF_FFFF, "R9");
        op(1, 0, 7'h45, 32'h1000_03FF, "R9");
        op(1, 0, 7'h01, 32'h00_00_9B_18, "R3");
        // R3 bypass lets the locked byte change
        op(1, 0, 7'h01, 32'h00_00_01_18, "R3");
        op(1, 0, 7'h45, 32'h0000_1234, "R4");
        op(1, 0, 7'h01, 32'h00_00_9B_18, "R3");
        op(1, 0, 7'h20, 32'h0, "R7");
        op(1, 0, 7'h01, 32'h0F_0E_07_19, "R3");
        // R4 address locks
        op(1, 0, 7'h45, 32'h0000_7777, "R4");
        op(1, 0, 7'h02, 32'h00_00_88_00, "R4");
        op(1, 0, 7'h48, 32'h0000_0800, "R4");
        op(1, 0, 7'h49, 32'h0000_0900, "R4");
        op(1, 0, 7'h4A, 32'h0000_0A00, "R4");
        op(0, 1, 7'h48, 0, "R4");
        // R7 refused while locked
        op(1, 1, 7'h20, 32'h4, "R7");
        op(0, 1, 7'h20, 0, "R7");
        // R6 sticky flags
        op(1, 0, 7'h20, 32'h3, "R6");
        op(1, 1, 7'h20, 32'h0, "R6");
        // R8 lockdown value filter
        op(1, 0, 7'h03, 32'h03_06_81_85, "R8");
        op(0, 1, 7'h03, 0, "R8");
        op(0, 0, 7'h00, 0, "R8");
        $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        miscompares++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
        $finish;
    end
endmodule